// File: doc/BRIEF.md
# Multi-Stream Sequential Prefetch Buffer

This block sits beside a first-level cache, on the cache's miss path. It holds several independent stream FIFOs. Each FIFO is loaded with the cache lines that follow an address that missed. When the cache misses, it asks this block for the line. Only the oldest entry (the head) of each stream is compared with the request. If a head matches and its data has arrived, the line goes back to the cache and that stream moves forward by one line. The freed slot then fetches the next sequential line. If no head matches, the stream used least recently is flushed and restarted just past the missing address. Prefetched lines stay in the streams and never go into the cache by themselves.

Toward memory the block drives a request port. Each request carries a line address and an opaque tag, and many requests may be outstanding. Responses may come back in any order and are matched by their tag. Because several streams run side by side, two or more interleaved sequential reference patterns can each be followed without evicting one another.

Top module: `stream_prefetch`

## Requirements
- R1: While reset is asserted, and after it until the first lookup is accepted, `lk_done` stays low and `mf_valid` stays low.
- R2: A lookup that matches no stream head completes one cycle after acceptance with `lk_hit`=0. The replaced stream then requests lines a+1, a+2, ..., a+DEPTH in that order.
- R3: A lookup that matches a head whose data is present completes one cycle after acceptance with `lk_hit`=1 and `lk_data` equal to that line's data. `lk_done` is only raised in answer to a `lk_valid` request.
- R4: A head hit removes the head entry and causes exactly one new request, for the line DEPTH lines past the hit address. A cycle never both advances and replaces streams, and never acts on more than one stream.
- R5: A lookup that matches a head whose request is still in flight is held. `lk_done` stays low until that line's response arrives, and the lookup then completes as a hit with the correct data.
- R6: Only stream heads are compared. An address held deeper in a stream, but not at its head, counts as a miss.
- R7: On a miss, the stream replaced is the one whose last hit or allocation is oldest. Before any use, stream 0 is replaced first, then 1, and so on. When several heads match, the lowest-numbered stream serves the hit.
- R8: Memory echoes `mf_tag` unchanged on `mr_tag`. A response to a request issued before its stream was flushed is discarded and never returned as data.
- R9: With two sequential address sequences interleaved in any order, every lookup after each sequence's first miss hits a stream head.
- R10: While `mf_valid` is high and `mf_ready` is low, the request holds: `mf_valid` stays high and `mf_addr` and `mf_tag` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request, held until `lk_done` |
| lk_addr | input | ADDR_W | Line address that missed in the cache |
| lk_done | output | 1 | One-cycle completion pulse for the current lookup |
| lk_hit | output | 1 | Lookup was served by a stream head |
| lk_data | output | DATA_W | Line data on a hit |
| mf_valid | output | 1 | Line request to memory valid |
| mf_ready | input | 1 | Memory accepts the request this cycle |
| mf_addr | output | ADDR_W | Line address requested |
| mf_tag | output | SW+PW+EPOCH_W | Request tag: {stream, slot, epoch} |
| mr_valid | input | 1 | Memory response valid |
| mr_tag | input | SW+PW+EPOCH_W | Tag of the answered request |
| mr_data | input | DATA_W | Returned line data |

## Verification
The bench holds memory off right after an allocation and then asks for the first prefetched line. A design that did not wait on the in-flight bit would answer early with stale or zero data. To target flushes while requests are in flight, it uses a long memory latency and cycles through all streams. A design that accepted any response for the right slot would then return a line from the old stream. It also asks for a line that sits just behind a head, which a design comparing every entry would wrongly report as a hit. A directed LRU sequence and long interleaved and random runs, checked against a bench-side model of heads and age stamps, catch a wrong victim or a wrong refill address (one line off, or a missing refill), because later lookups then miss.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  // outcome of the lookup presented this cycle
  typedef enum logic [1:0] {
    LK_IDLE,
    LK_HIT,
    LK_STALL,
    LK_MISS
  } lk_act_e;
endpackage

// File: rtl/sbuf_way.sv
// One stream: a fixed ring of DEPTH line slots, always full once allocated.
module sbuf_way #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 4,
  parameter int EPOCH_W = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              pop,
  output logic              head_valid,
  output logic              head_avail,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [PW-1:0]     fetch_slot,
  output logic [EPOCH_W-1:0] epoch,
  input  logic              fetch_fire,
  input  logic              rsp_hit,
  input  logic [PW-1:0]     rsp_slot,
  input  logic [EPOCH_W-1:0] rsp_epoch,
  input  logic [DATA_W-1:0] rsp_data
);

  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [DEPTH-1:0]  issued_q;
  logic [DEPTH-1:0]  avail_q;
  logic              live_q;
  logic [PW-1:0]     head_q;
  logic [EPOCH_W-1:0] epoch_q;
  logic              fill_ok;

  // slot that lies k places after p around the ring
  function automatic logic [PW-1:0] ring_at(input logic [PW-1:0] p, input int k);
    int s;
    s = int'(p) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  // address a slot takes when its head line is consumed
  function automatic logic [ADDR_W-1:0] refill_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(DEPTH);
  endfunction

  assign head_valid = live_q;
  assign head_avail = avail_q[head_q];
  assign head_addr  = ent_addr[head_q];
  assign head_data  = ent_data[head_q];
  assign epoch      = epoch_q;

  // oldest slot not yet requested from memory
  always_comb begin
    fetch_req  = 1'b0;
    fetch_slot = '0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      if (live_q && !issued_q[ring_at(head_q, j)]) begin
        fetch_req  = 1'b1;
        fetch_slot = ring_at(head_q, j);
      end
    end
  end
  assign fetch_addr = ent_addr[fetch_slot];

  assign fill_ok = rsp_hit && (rsp_epoch == epoch_q) && live_q &&
                   issued_q[rsp_slot] && !avail_q[rsp_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q   <= 1'b0;
      head_q   <= '0;
      epoch_q  <= '0;
      issued_q <= '0;
      avail_q  <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        ent_addr[k] <= '0;
        ent_data[k] <= '0;
      end
    end else begin
      if (fill_ok) begin
        avail_q[rsp_slot]  <= 1'b1;
        ent_data[rsp_slot] <= rsp_data;
      end
      if (fetch_fire) issued_q[fetch_slot] <= 1'b1;
      if (pop) begin
        ent_addr[head_q] <= refill_addr(ent_addr[head_q]);
        issued_q[head_q] <= 1'b0;
        avail_q[head_q]  <= 1'b0;
        head_q           <= ring_at(head_q, 1);
      end
      if (alloc) begin
        for (int k = 0; k < DEPTH; k++) begin
          ent_addr[k] <= alloc_addr + ADDR_W'(k);
        end
        issued_q <= '0;
        avail_q  <= '0;
        head_q   <= '0;
        epoch_q  <= epoch_q + 1'b1;
        live_q   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sbuf_lru.sv
// Age ranks: 0 = most recent, N-1 = next victim.
module sbuf_lru #(
  parameter int N  = 4,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [SW-1:0] touch_idx,
  output logic [SW-1:0] victim
);

  logic [SW-1:0] age_q [N];

  always_comb begin
    victim = '0;
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == SW'(N - 1)) victim = SW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= SW'(N - 1 - i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (SW'(i) == touch_idx) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sbuf_fetch_q.sv
// Picks one stream's pending line and holds it in a request register.
module sbuf_fetch_q #(
  parameter int N       = 4,
  parameter int ADDR_W  = 16,
  parameter int SW      = 2,
  parameter int PW      = 2,
  parameter int EPOCH_W = 2,
  localparam int TAG_W  = SW + PW + EPOCH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       way_req,
  input  logic [ADDR_W-1:0]  way_addr [N],
  input  logic [PW-1:0]      way_slot [N],
  input  logic [EPOCH_W-1:0] way_epoch [N],
  output logic [N-1:0]       way_fire,
  output logic               mf_valid,
  input  logic               mf_ready,
  output logic [ADDR_W-1:0]  mf_addr,
  output logic [TAG_W-1:0]   mf_tag
);

  logic              pick_any;
  logic [SW-1:0]     pick_idx;
  logic              load;
  logic              oq_valid;
  logic [ADDR_W-1:0] oq_addr;
  logic [TAG_W-1:0]  oq_tag;

  always_comb begin
    pick_any = 1'b0;
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (way_req[i]) begin
        pick_any = 1'b1;
        pick_idx = SW'(i);
      end
    end
  end

  assign load     = pick_any && (!oq_valid || mf_ready);
  assign way_fire = load ? (N'(1) << pick_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oq_valid <= 1'b0;
      oq_addr  <= '0;
      oq_tag   <= '0;
    end else if (load) begin
      oq_valid <= 1'b1;
      oq_addr  <= way_addr[pick_idx];
      oq_tag   <= {pick_idx, way_slot[pick_idx], way_epoch[pick_idx]};
    end else if (mf_ready) begin
      oq_valid <= 1'b0;
    end
  end

  assign mf_valid = oq_valid;
  assign mf_addr  = oq_addr;
  assign mf_tag   = oq_tag;

endmodule

// File: rtl/stream_prefetch.sv
module stream_prefetch
  import sbuf_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int NSTREAM = 4,
  parameter int DEPTH   = 4,
  parameter int EPOCH_W = 2,
  localparam int SW     = (NSTREAM > 1) ? $clog2(NSTREAM) : 1,
  localparam int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TAG_W  = SW + PW + EPOCH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              mf_valid,
  input  logic              mf_ready,
  output logic [ADDR_W-1:0] mf_addr,
  output logic [TAG_W-1:0]  mf_tag,
  input  logic              mr_valid,
  input  logic [TAG_W-1:0]  mr_tag,
  input  logic [DATA_W-1:0] mr_data
);

  logic [NSTREAM-1:0] hd_valid, hd_avail, hd_match;
  logic [NSTREAM-1:0] pop_vec, alloc_vec, way_req, way_fire, way_rsp;
  logic [ADDR_W-1:0]  hd_addr   [NSTREAM];
  logic [DATA_W-1:0]  hd_data   [NSTREAM];
  logic [ADDR_W-1:0]  way_addr  [NSTREAM];
  logic [PW-1:0]      way_slot  [NSTREAM];
  logic [EPOCH_W-1:0] way_epoch [NSTREAM];

  logic [SW-1:0]      rsp_stream;
  logic [PW-1:0]      rsp_slot;
  logic [EPOCH_W-1:0] rsp_epoch;

  logic               accept, lk_stall, touch;
  logic [SW-1:0]      hit_idx, victim, touch_idx;
  logic [ADDR_W-1:0]  start_addr;
  lk_act_e            act;
  logic               done_q, hit_q;
  logic [DATA_W-1:0]  data_q;

  function automatic logic [SW-1:0] lowest_set(input logic [NSTREAM-1:0] v);
    logic [SW-1:0] r;
    r = '0;
    for (int i = NSTREAM - 1; i >= 0; i--) if (v[i]) r = SW'(i);
    return r;
  endfunction

  // first line a freshly allocated stream holds
  function automatic logic [ADDR_W-1:0] first_line(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  // response tag fields: {stream, slot, epoch}
  assign rsp_stream = mr_tag[TAG_W-1 -: SW];
  assign rsp_slot   = mr_tag[EPOCH_W +: PW];
  assign rsp_epoch  = mr_tag[EPOCH_W-1:0];

  always_comb begin
    for (int i = 0; i < NSTREAM; i++) begin
      hd_match[i] = hd_valid[i] && (hd_addr[i] == lk_addr);
      way_rsp[i]  = mr_valid && (rsp_stream == SW'(i));
    end
  end

  assign accept  = lk_valid && !done_q;
  assign hit_idx = lowest_set(hd_match);

  always_comb begin
    if (!accept)               act = LK_IDLE;
    else if (|hd_match)        act = hd_avail[hit_idx] ? LK_HIT : LK_STALL;
    else                       act = LK_MISS;
  end

  assign lk_stall   = (act == LK_STALL);
  assign pop_vec    = (act == LK_HIT)  ? (NSTREAM'(1) << hit_idx) : '0;
  assign alloc_vec  = (act == LK_MISS) ? (NSTREAM'(1) << victim)  : '0;
  assign touch      = (act == LK_HIT) || (act == LK_MISS);
  assign touch_idx  = (act == LK_HIT) ? hit_idx : victim;
  assign start_addr = first_line(lk_addr);

  genvar g;
  generate
    for (g = 0; g < NSTREAM; g++) begin : g_way
      sbuf_way #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .EPOCH_W(EPOCH_W)
      ) u_way (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (alloc_vec[g]),
        .alloc_addr (start_addr),
        .pop        (pop_vec[g]),
        .head_valid (hd_valid[g]),
        .head_avail (hd_avail[g]),
        .head_addr  (hd_addr[g]),
        .head_data  (hd_data[g]),
        .fetch_req  (way_req[g]),
        .fetch_addr (way_addr[g]),
        .fetch_slot (way_slot[g]),
        .epoch      (way_epoch[g]),
        .fetch_fire (way_fire[g]),
        .rsp_hit    (way_rsp[g]),
        .rsp_slot   (rsp_slot),
        .rsp_epoch  (rsp_epoch),
        .rsp_data   (mr_data)
      );
    end
  endgenerate

  sbuf_lru #(.N(NSTREAM), .SW(SW)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (touch),
    .touch_idx (touch_idx),
    .victim    (victim)
  );

  sbuf_fetch_q #(
    .N(NSTREAM), .ADDR_W(ADDR_W), .SW(SW), .PW(PW), .EPOCH_W(EPOCH_W)
  ) u_fq (
    .clk       (clk),
    .rst_n     (rst_n),
    .way_req   (way_req),
    .way_addr  (way_addr),
    .way_slot  (way_slot),
    .way_epoch (way_epoch),
    .way_fire  (way_fire),
    .mf_valid  (mf_valid),
    .mf_ready  (mf_ready),
    .mf_addr   (mf_addr),
    .mf_tag    (mf_tag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      hit_q  <= 1'b0;
      data_q <= '0;
    end else begin
      done_q <= touch;
      hit_q  <= (act == LK_HIT);
      if (act == LK_HIT) data_q <= hd_data[hit_idx];
    end
  end

  assign lk_done = done_q;
  assign lk_hit  = hit_q;
  assign lk_data = data_q;

endmodule

// File: rtl/stream_prefetch_chk.sv
module stream_prefetch_chk #(
  parameter int ADDR_W  = 16,
  parameter int TAG_W   = 6,
  parameter int NSTREAM = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_done,
  input logic               lk_hit,
  input logic               lk_stall,
  input logic [NSTREAM-1:0] pop_vec,
  input logic [NSTREAM-1:0] alloc_vec,
  input logic               mf_valid,
  input logic               mf_ready,
  input logic [ADDR_W-1:0]  mf_addr,
  input logic [TAG_W-1:0]   mf_tag
);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mf_valid && !mf_ready |=> mf_valid && $stable(mf_addr) && $stable(mf_tag));

  // R5
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_stall |=> !lk_done);

  // R3
  pop_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pop_vec) |=> lk_done && lk_hit);

  // R2
  alloc_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|alloc_vec) |=> lk_done && !lk_hit);

  // R4
  single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_vec, alloc_vec}));

  // R3
  done_asked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> $past(lk_valid));

endmodule

bind stream_prefetch stream_prefetch_chk #(
  .ADDR_W(ADDR_W), .TAG_W(TAG_W), .NSTREAM(NSTREAM)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_done   (lk_done),
  .lk_hit    (lk_hit),
  .lk_stall  (lk_stall),
  .pop_vec   (pop_vec),
  .alloc_vec (alloc_vec),
  .mf_valid  (mf_valid),
  .mf_ready  (mf_ready),
  .mf_addr   (mf_addr),
  .mf_tag    (mf_tag)
);

// File: tb/stream_prefetch_tb.sv
module stream_prefetch_tb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NS = 4;
  localparam int DP = 4;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic lk_done, lk_hit;
  logic [DW-1:0] lk_data;
  logic mf_valid;
  logic mf_ready = 1'b0;
  logic [AW-1:0] mf_addr;
  logic [TW-1:0] mf_tag;
  logic mr_valid = 1'b0;
  logic [TW-1:0] mr_tag = '0;
  logic [DW-1:0] mr_data = '0;

  int checks = 0;
  int errors = 0;

  stream_prefetch u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_data(lk_data),
    .mf_valid(mf_valid), .mf_ready(mf_ready), .mf_addr(mf_addr), .mf_tag(mf_tag),
    .mr_valid(mr_valid), .mr_tag(mr_tag), .mr_data(mr_data)
  );

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] line_data(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: fixed latency ring, random ready
  int cyc = 0;
  int mem_lat = 4;
  int ready_pct = 100;
  bit mem_stall = 1'b0;
  bit sch_v [16];
  logic [TW-1:0] sch_t [16];
  logic [DW-1:0] sch_d [16];
  logic [AW-1:0] fa_log [1024];
  int log_cnt = 0;
  bit prev_hold = 1'b0;
  logic [AW-1:0] prev_addr;
  logic [TW-1:0] prev_tag;

  initial for (int i = 0; i < 16; i++) sch_v[i] = 1'b0;

  always @(negedge clk) begin
    int k;
    if (!rst_n) begin
      chk(!lk_done && !mf_valid, "R1 reset", {lk_done, mf_valid}, 0);
      mf_ready = 1'b0;
      mr_valid = 1'b0;
    end else begin
      cyc++;
      if (prev_hold)
        chk(mf_valid && mf_addr == prev_addr && mf_tag == prev_tag, "R10 hold",
            mf_addr, prev_addr);
      mf_ready = !mem_stall && ($urandom_range(99) < ready_pct);
      prev_hold = mf_valid && !mf_ready;
      prev_addr = mf_addr;
      prev_tag  = mf_tag;
      if (mf_valid && mf_ready) begin
        k = (cyc + mem_lat) % 16;
        sch_v[k] = 1'b1;
        sch_t[k] = mf_tag;
        sch_d[k] = line_data(mf_addr);
        if (log_cnt < 1024) fa_log[log_cnt] = mf_addr;
        log_cnt++;
      end
      k = cyc % 16;
      mr_valid = sch_v[k];
      mr_tag   = sch_t[k];
      mr_data  = sch_d[k];
      sch_v[k] = 1'b0;
    end
  end

  // reference model: head address and last-use stamp per stream
  logic [AW-1:0] m_head [NS];
  bit m_live [NS];
  int m_stamp [NS];
  int m_clk = NS;
  initial for (int i = 0; i < NS; i++) begin m_live[i] = 0; m_stamp[i] = i; m_head[i] = '0; end

  function automatic bit model_access(input logic [AW-1:0] a);
    int v;
    for (int i = 0; i < NS; i++) begin
      if (m_live[i] && m_head[i] == a) begin
        m_head[i] = a + 1'b1;
        m_stamp[i] = m_clk++;
        return 1'b1;
      end
    end
    v = 0;
    for (int i = 1; i < NS; i++) if (m_stamp[i] < m_stamp[v]) v = i;
    m_head[v] = a + 1'b1;
    m_live[v] = 1'b1;
    m_stamp[v] = m_clk++;
    return 1'b0;
  endfunction

  task automatic lookup(input logic [AW-1:0] a, output logic hit, output logic [DW-1:0] d,
                        output int lat);
    bit got;
    got = 0;
    lat = 0;
    @(negedge clk);
    lk_addr = a;
    lk_valid = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      lat++;
      if (lk_done) begin got = 1; break; end
    end
    hit = lk_hit;
    d = lk_data;
    lk_valid = 1'b0;
    if (!got) chk(0, "lookup timeout", a, 0);
  endtask

  task automatic access(input logic [AW-1:0] a, input string req);
    logic h; logic [DW-1:0] d; int lat; bit e;
    e = model_access(a);
    lookup(a, h, d, lat);
    chk(h == e, req, h, e);
    if (e && h) chk(d == line_data(a), {req, " data"}, d, line_data(a));
  endtask

  task automatic access_e(input logic [AW-1:0] a, input bit exp, input string req);
    logic h; logic [DW-1:0] d; int lat; bit e;
    e = model_access(a);
    lookup(a, h, d, lat);
    chk(h == exp && e == exp, req, h, exp);
    if (exp && h) chk(d == line_data(a), {req, " data"}, d, line_data(a));
  endtask

  task automatic drain();
    @(posedge clk);
    ready_pct = 100;
    mem_stall = 1'b0;
    repeat (40) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic h; logic [DW-1:0] d; int lat; int base; bit quiet; bit got;
    logic [AW-1:0] a, b, c, dd;
    logic [AW-1:0] sq [3];
    void'($urandom(32'd20240611));

    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mf_valid && !lk_done, "R1 idle after reset", mf_valid, 0);

    // R2: miss and ascending prefetch order
    @(posedge clk);
    base = log_cnt;
    a = 16'h0100;
    access_e(a, 0, "R2 miss");
    repeat (20) @(posedge clk);
    chk(log_cnt == base + DP, "R2 count", log_cnt - base, DP);
    for (int k = 0; k < DP; k++)
      chk(fa_log[base + k] == a + AW'(k + 1), "R2 order", fa_log[base + k], a + AW'(k + 1));

    // R3 + R4: immediate hit and the refill request
    void'(model_access(a + 1'b1));
    lookup(a + 1'b1, h, d, lat);
    chk(h == 1'b1, "R3 hit", h, 1);
    chk(d == line_data(a + 1'b1), "R3 data", d, line_data(a + 1'b1));
    chk(lat == 1, "R3 latency", lat, 1);
    repeat (20) @(posedge clk);
    chk(log_cnt == base + DP + 1, "R4 one refill", log_cnt - base, DP + 1);
    chk(fa_log[base + DP] == a + AW'(1 + DP), "R4 refill addr", fa_log[base + DP], a + AW'(1 + DP));

    // R6: line behind the head is not seen
    access_e(a + 16'd3, 0, "R6 non-head miss");

    // R5: head in flight holds the lookup
    drain();
    mem_stall = 1'b1;
    b = 16'h0800;
    access_e(b, 0, "R5 setup miss");
    void'(model_access(b + 1'b1));
    @(negedge clk);
    lk_addr = b + 1'b1;
    lk_valid = 1'b1;
    quiet = 1;
    repeat (30) begin
      @(negedge clk);
      if (lk_done) quiet = 0;
    end
    chk(quiet, "R5 no done while in flight", !quiet, 0);
    @(posedge clk) mem_stall = 1'b0;
    got = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (lk_done) begin got = 1; break; end
    end
    chk(got && lk_hit, "R5 completes as hit", lk_hit, 1);
    chk(lk_data == line_data(b + 1'b1), "R5 data", lk_data, line_data(b + 1'b1));
    lk_valid = 1'b0;

    // R7: least recently used stream is replaced
    drain();
    access_e(16'h2000, 0, "R7 alloc P");
    access_e(16'h3000, 0, "R7 alloc Q");
    access_e(16'h4000, 0, "R7 alloc R");
    access_e(16'h5000, 0, "R7 alloc S");
    access_e(16'h2001, 1, "R7 touch P");
    access_e(16'h6000, 0, "R7 alloc T");
    access_e(16'h2002, 1, "R7 P kept");
    access_e(16'h4001, 1, "R7 R kept");
    access_e(16'h5001, 1, "R7 S kept");
    access_e(16'h3001, 0, "R7 Q evicted");

    // R8: flush while requests are in flight
    drain();
    @(posedge clk) mem_lat = 12;
    for (int k = 0; k < 5; k++) access_e(16'h7000 + AW'(k * 256), 0, "R8 cycle streams");
    access_e(16'h7401, 1, "R8 fresh data");
    access_e(16'h7402, 1, "R8 fresh data");
    access_e(16'h7403, 1, "R8 fresh data");

    // R9: two interleaved sequences
    drain();
    @(posedge clk);
    mem_lat = 6;
    ready_pct = 70;
    c = 16'h8000;
    dd = 16'h9000;
    access_e(c, 0, "R9 warm-up");
    access_e(dd, 0, "R9 warm-up");
    c++;
    dd++;
    for (int n = 0; n < 200; n++) begin
      if ($urandom_range(1) == 0) begin access_e(c, 1, "R9 seq A"); c++; end
      else begin access_e(dd, 1, "R9 seq B"); dd++; end
    end

    // mixed random traffic against the model
    drain();
    @(posedge clk);
    mem_lat = 3;
    ready_pct = 80;
    sq[0] = 16'hA000; sq[1] = 16'hB000; sq[2] = 16'hC000;
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(9) < 7) begin
        int s;
        s = $urandom_range(2);
        access(sq[s], "R3 R7 random seq");
        sq[s]++;
      end else begin
        access(16'hA000 + AW'($urandom_range(63)), "R6 R7 random jump");
      end
    end

    drain();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule